// File: doc/BRIEF.md
# Four-Channel Load Fault Supervisor

This block supervises four low-side switched channels. Each channel has a commanded on/off bit, a raw current-limit flag and a raw low-voltage flag. A global enable and a global over-temperature flag apply to all four. The block filters the two raw flags with tick-counted deglitch timers and holds one overcurrent latch and one open-load latch per channel. After an overcurrent trip it keeps the channel switched off for a fixed retry interval and then clears the fault. It drives the per-channel gate enables, a per-channel fault vector and one active-low summary fault line.

Every time constant is given in nanoseconds and converted to clock ticks from the clock frequency in kHz. The overcurrent latch clears when its command bit is low. The open-load latch clears when its command bit is high. A serial front end can therefore clear either fault by writing the opposite command value. Over-temperature is not latched. While it is present it forces every channel off and pulls the summary line low, and operation resumes when it goes away.

Top module: `chan_fault_sup`

## Requirements
- R1: `drive_o[i]` is high exactly when `cmd_i[i]` is high, `enable_i` is high, channel i is not in an overcurrent retry interval, and `otemp_i` is low.
- R2: When `ilim_i[i]` is high on OCP_TICKS consecutive rising edges while `drive_o[i]` is high, the overcurrent latch of channel i is set after that edge. A streak that breaks earlier restarts the count from zero.
- R3: The overcurrent trip holds `drive_o[i]` low for exactly RETRY_TICKS cycles after the latch sets. The latch clears on the last edge of that interval, and the channel then follows R1 again.
- R4: The overcurrent latch clears on any edge where `cmd_i[i]` is low. A retry interval already running continues to its end.
- R5: `olv_i[i]` counts toward open load only while `drive_o[i]` is low. OL_TICKS consecutive such edges set the open-load latch. A shorter streak leaves it clear.
- R6: The open-load latch clears on any edge where `cmd_i[i]` is high. This clear takes priority over setting.
- R7: `fault_n_o` is low exactly when any latch of any channel is set or `otemp_i` is high.
- R8: While `otemp_i` is high, all bits of `drive_o` are low and no latch is set by it. When it falls, the outputs follow R1 with no delay.
- R9: A cycle with `rst_i` high (synchronous, active high) clears every latch, deglitch count and retry interval on that edge.
- R10: `fault_o[i]` is the OR of channel i's overcurrent and open-load latches. Bit i of every vector port belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Global output enable, active high |
| otemp_i | input | 1 | Over-temperature flag |
| cmd_i | input | NUM_CH | Commanded on bit per channel |
| ilim_i | input | NUM_CH | Raw current-limit flag per channel |
| olv_i | input | NUM_CH | Raw low output voltage flag per channel |
| drive_o | output | NUM_CH | Gate enable per channel |
| fault_o | output | NUM_CH | Latched fault per channel |
| fault_n_o | output | 1 | Active-low summary fault |

## Verification
The hardest condition to reach is an overcurrent trip whose command bit is dropped and raised again inside the retry window. The latch must clear while the channel stays forced off until the interval ends. The bench reaches this with a directed sequence: it holds the current-limit flag for exactly the deglitch length, pulses the command low, and counts the cycles up to the edge where drive returns. It also applies a streak one cycle short of each threshold, and a reset in the middle of a retry. A random phase with sticky flags then compares every cycle against a behavioural model.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef struct packed {
        logic ocp;
        logic ol;
    } fsup_latch_t;

    function automatic int unsigned ns_to_ticks(int unsigned khz, int unsigned ns);
        longint unsigned t;
        t = (longint'(khz) * longint'(ns)) / 64'd1000000;
        if (t == 0) t = 1;
        return int'(t);
    endfunction

endpackage

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
    parameter int unsigned THRESH = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cond_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dg_state_t;

    dg_state_t st_d, st_q;

    assign hit_o = cond_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (rst_i || !cond_i || hit_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // R2 / R5: the streak counter never runs past its threshold
    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.cnt <= LAST);

    // R2 / R5: a dropped condition restarts the count
    p_restart_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !cond_i |=> st_q.cnt == '0);

endmodule

// File: rtl/fsup_channel.sv
module fsup_channel
    import fsup_pkg::*;
#(
    parameter int unsigned OCP_T   = 8,
    parameter int unsigned OL_T    = 16,
    parameter int unsigned RETRY_T = 64
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cmd_i,
    input  logic en_i,
    input  logic otemp_i,
    input  logic ilim_i,
    input  logic olv_i,
    output logic drive_o,
    output logic fault_o
);
    localparam int unsigned RW = $clog2(RETRY_T + 1);
    localparam logic [RW-1:0] RETRY_LOAD = RW'(RETRY_T);
    localparam logic [RW-1:0] RETRY_LAST = RW'(1);

    typedef struct packed {
        fsup_latch_t   lat;
        logic [RW-1:0] retry;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      retry_active;
    logic      ocp_hit, ol_hit;

    assign retry_active = (st_q.retry != '0);
    assign drive_o      = cmd_i & en_i & ~retry_active & ~otemp_i;
    assign fault_o      = st_q.lat.ocp | st_q.lat.ol;

    fsup_deglitch #(.THRESH(OCP_T)) u_ocp_dg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cond_i(drive_o & ilim_i),
        .hit_o (ocp_hit)
    );

    fsup_deglitch #(.THRESH(OL_T)) u_ol_dg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cond_i(~drive_o & olv_i),
        .hit_o (ol_hit)
    );

    always_comb begin
        st_d = st_q;
        if (ocp_hit) begin
            st_d.retry = RETRY_LOAD;
        end else if (retry_active) begin
            st_d.retry = st_q.retry - 1'b1;
        end

        if (ocp_hit) begin
            st_d.lat.ocp = 1'b1;
        end else if (!cmd_i || st_q.retry == RETRY_LAST) begin
            st_d.lat.ocp = 1'b0;
        end

        if (cmd_i) begin
            st_d.lat.ol = 1'b0;
        end else if (ol_hit) begin
            st_d.lat.ol = 1'b1;
        end

        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    p_off_in_retry_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        retry_active |-> !drive_o);

    p_trip_starts_retry_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.lat.ocp) |-> retry_active);

    p_ocp_clear_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !cmd_i |=> !st_q.lat.ocp);

    p_ol_clear_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i |=> !st_q.lat.ol);

endmodule

// File: rtl/chan_fault_sup.sv
module chan_fault_sup
    import fsup_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned CLK_KHZ  = 100000,
    parameter int unsigned OCP_NS   = 3500,
    parameter int unsigned OL_NS    = 15000,
    parameter int unsigned RETRY_NS = 1200000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              enable_i,
    input  logic              otemp_i,
    input  logic [NUM_CH-1:0] cmd_i,
    input  logic [NUM_CH-1:0] ilim_i,
    input  logic [NUM_CH-1:0] olv_i,
    output logic [NUM_CH-1:0] drive_o,
    output logic [NUM_CH-1:0] fault_o,
    output logic              fault_n_o
);
    localparam int unsigned OCP_TICKS   = ns_to_ticks(CLK_KHZ, OCP_NS);
    localparam int unsigned OL_TICKS    = ns_to_ticks(CLK_KHZ, OL_NS);
    localparam int unsigned RETRY_TICKS = ns_to_ticks(CLK_KHZ, RETRY_NS);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fsup_channel #(
            .OCP_T  (OCP_TICKS),
            .OL_T   (OL_TICKS),
            .RETRY_T(RETRY_TICKS)
        ) u_ch (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .cmd_i  (cmd_i[g]),
            .en_i   (enable_i),
            .otemp_i(otemp_i),
            .ilim_i (ilim_i[g]),
            .olv_i  (olv_i[g]),
            .drive_o(drive_o[g]),
            .fault_o(fault_o[g])
        );
    end

    assign fault_n_o = ~((|fault_o) | otemp_i);

    p_otemp_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        otemp_i |-> drive_o == '0);

    p_reset_clear_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> fault_o == '0);

    p_fault_line_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (fault_o != '0) |-> !fault_n_o);

endmodule

// File: tb/chan_fault_sup_tb_top.sv
module chan_fault_sup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N       = 4;
    localparam int OCP_T   = 14;
    localparam int OL_T    = 60;
    localparam int RETRY_T = 4800;

    logic         clk = 1'b0;
    logic         rst, en, otemp;
    logic [N-1:0] cmd, ilim, olv;
    logic [N-1:0] drive, fault;
    logic         fault_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    int m_ocp_run[N], m_ol_run[N], m_retry[N];
    bit m_ocp[N], m_ol[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_fault_sup #(
        .NUM_CH(N), .CLK_KHZ(4000), .OCP_NS(3500), .OL_NS(15000), .RETRY_NS(1200000)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .enable_i(en), .otemp_i(otemp),
        .cmd_i(cmd), .ilim_i(ilim), .olv_i(olv),
        .drive_o(drive), .fault_o(fault), .fault_n_o(fault_n)
    );

    function automatic bit m_drive(int i);
        return cmd[i] && en && (m_retry[i] == 0) && !otemp;
    endfunction

    function automatic logic [N-1:0] m_drive_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_drive(i);
        return v;
    endfunction

    function automatic logic [N-1:0] m_fault_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_ocp[i] | m_ol[i];
        return v;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < N; i++) begin
            bit d, trip, olhit;
            d = m_drive(i);
            if (rst) begin
                m_ocp_run[i] = 0; m_ol_run[i] = 0; m_retry[i] = 0;
                m_ocp[i] = 0; m_ol[i] = 0;
            end else begin
                trip  = d && ilim[i] && (m_ocp_run[i] == OCP_T - 1);
                olhit = !d && olv[i] && (m_ol_run[i] == OL_T - 1);
                m_ocp_run[i] = (d && ilim[i] && !trip) ? m_ocp_run[i] + 1 : 0;
                m_ol_run[i]  = (!d && olv[i] && !olhit) ? m_ol_run[i] + 1 : 0;
                if (trip) m_ocp[i] = 1;
                else if (!cmd[i] || m_retry[i] == 1) m_ocp[i] = 0;
                if (trip) m_retry[i] = RETRY_T;
                else if (m_retry[i] > 0) m_retry[i] = m_retry[i] - 1;
                if (cmd[i]) m_ol[i] = 0;
                else if (olhit) m_ol[i] = 1;
            end
        end
    endtask

    // compare outputs with the model, then take one clock edge
    task automatic step();
        #1;
        check(drive === m_drive_vec(), "R1 drive_o vs model", int'(drive), int'(m_drive_vec()));
        check(fault === m_fault_vec(), "R10 fault_o vs model", int'(fault), int'(m_fault_vec()));
        check(fault_n === !((|m_fault_vec()) || otemp), "R7 fault_n_o vs model",
              int'(fault_n), int'(!((|m_fault_vec()) || otemp)));
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=200000", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_ocp_run[i] = 0; m_ol_run[i] = 0; m_retry[i] = 0; m_ocp[i] = 0; m_ol[i] = 0;
        end
        rst = 1; en = 0; otemp = 0; cmd = '0; ilim = '0; olv = '0;
        @(negedge clk);
        run(3);
        rst = 0;
        #1;
        check(fault_n === 1'b1 && fault === '0 && drive === '0, "R9 reset state",
              int'({fault_n, fault, drive}), int'({1'b1, 4'h0, 4'h0}));

        // R1: enable gating
        cmd = 4'b1111; en = 1; run(1);
        #1; check(drive === 4'b1111, "R1 all driven", int'(drive), 15);
        en = 0; run(1);
        #1; check(drive === 4'b0000, "R1 enable low", int'(drive), 0);
        en = 1; run(1);

        // R2: short streak does not trip, full streak trips
        ilim[0] = 1; run(OCP_T - 1);
        ilim[0] = 0; run(1);
        #1; check(fault[0] === 1'b0, "R2 short streak", int'(fault[0]), 0);
        ilim[0] = 1; run(OCP_T);
        ilim[0] = 0;
        #1; check(fault[0] === 1'b1 && drive[0] === 1'b0, "R2 trip after streak",
                  int'({fault[0], drive[0]}), 2);
        check(fault_n === 1'b0, "R7 fault line low on ocp", int'(fault_n), 0);

        // R3: exact retry length
        run(RETRY_T - 1);
        #1; check(drive[0] === 1'b0 && fault[0] === 1'b1, "R3 last retry cycle",
                  int'({fault[0], drive[0]}), 2);
        run(1);
        #1; check(drive[0] === 1'b1 && fault[0] === 1'b0, "R3 retry ended",
                  int'({fault[0], drive[0]}), 1);

        // R4: command low clears latch, retry keeps running
        ilim[1] = 1; run(OCP_T); ilim[1] = 0;
        cmd[1] = 0; run(1);
        cmd[1] = 1;
        #1; check(fault[1] === 1'b0 && drive[1] === 1'b0, "R4 latch cleared, still off",
                  int'({fault[1], drive[1]}), 0);
        run(100);
        #1; check(drive[1] === 1'b0, "R4 retry continues", int'(drive[1]), 0);

        // R9: reset ends retry at once
        rst = 1; run(1); rst = 0;
        #1; check(drive[1] === 1'b1, "R9 reset ends retry", int'(drive[1]), 1);

        // R5: open load only while off
        olv[3] = 1; run(OL_T + 5);
        #1; check(fault[3] === 1'b0, "R5 no open load while driven", int'(fault[3]), 0);
        cmd[3] = 0; run(OL_T - 1);
        olv[3] = 0; run(1);
        #1; check(fault[3] === 1'b0, "R5 short open-load streak", int'(fault[3]), 0);
        olv[3] = 1; run(OL_T);
        #1; check(fault[3] === 1'b1, "R5 open load latched", int'(fault[3]), 1);

        // R10: per-channel mapping
        #1; check(fault === 4'b1000, "R10 fault vector mapping", int'(fault), 8);

        // R6: command high clears open load even with olv held
        cmd[3] = 1; run(1);
        #1; check(fault[3] === 1'b0, "R6 open load cleared", int'(fault[3]), 0);
        olv[3] = 0;

        // R8: over-temperature forces off, not latched
        otemp = 1; run(1);
        #1; check(drive === 4'b0000 && fault_n === 1'b0, "R8 otemp forces off",
                  int'({fault_n, drive}), 0);
        check(fault === 4'b0000, "R8 otemp not latched", int'(fault), 0);
        otemp = 0;
        #1; check(drive === 4'b1111 && fault_n === 1'b1, "R8 resume after otemp",
                  int'({fault_n, drive}), 31);
        run(2);

        // random phase with sticky flags
        for (int k = 0; k < 20000; k++) begin
            if ($urandom_range(0, 99) < 3) cmd[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 99) < 4) ilim[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 99) < 3) olv[$urandom_range(0, N-1)] ^= 1'b1;
            if ($urandom_range(0, 999) < 2) otemp = ~otemp;
            if ($urandom_range(0, 999) < 2) en = ~en;
            rst = ($urandom_range(0, 4999) == 0);
            step();
        end
        rst = 0;
        finish_run();
    end
endmodule